// File: doc/BRIEF.md
# Load Buffer Line Coalescer

This block gathers pending loads before they go to memory. Each load arrives as a cache-line address and a 16-bit byte-enable mask, with one bit for each byte of a 16-byte line. If a buffered row already holds the same line, the load is folded into that row's byte bitmap. Otherwise it takes a free row. Each row therefore builds up the union of all bytes requested from its line.

The block counts the set bits of every row's bitmap. It offers the row with the largest count to the memory side as the next line to fetch, and it raises a separate flag when that row's bitmap is all ones, which means the whole line is wanted. The memory side takes the offered row with a valid/ready handshake, and the row is released on the clock edge where the handshake completes. The request side uses its own valid/ready pair. Ready drops only when a load can neither merge nor find a free row.

Top module: `load_coalescer`

## Requirements
- R1: After reset, no row is offered (`dispValid` low) and `reqReady` is high.
- R2: A load whose line address matches a buffered row that is not departing in that cycle is merged into that row. The new bitmap is the old bitmap OR'd with `reqMask`, and only one dispatch results.
- R3: A load with no matching row is written to the lowest-indexed free row as a new entry. Different lines are dispatched as separate rows.
- R4: The offered row is the valid row whose bitmap has the largest number of set bits. `dispLine` and `dispMask` carry that row's address and bitmap.
- R5: When several valid rows share the largest count, the row with the lowest index is offered. Row indices are assigned by R3.
- R6: `dispFull` is high exactly when the offered bitmap equals 16'hFFFF.
- R7: With all four rows occupied, a load to a line not held in any row sees `reqReady` low. A load to a line already held is still accepted.
- R8: While `dispValid` is high and `dispReady` is low, the offer stays valid. A row is freed on the edge where `dispValid` and `dispReady` are both high, and is never offered again.
- R9: A load to the line of the row being dispatched in the same cycle is not merged into that row. It opens a new row, and that row is dispatched later carrying only the new load's mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Load request present |
| reqReady | output | 1 | Load request accepted this cycle |
| reqLine | input | ADDR_W | Cache-line address of the load |
| reqMask | input | 16 | Byte enables within the line |
| dispValid | output | 1 | A row is offered to memory |
| dispReady | input | 1 | Memory takes the offered row |
| dispLine | output | ADDR_W | Line address of the offered row |
| dispMask | output | 16 | Accumulated byte bitmap of the offered row |
| dispFull | output | 1 | Offered bitmap covers the whole line |

## Verification
A merge and a dispatch can hit the same row in one cycle. The bench provokes this by raising `dispReady` on the same edge where it presents a load to the line that is currently offered. It then expects two separate dispatch items: the old bitmap first, then a row holding only the new mask. Acceptance under a full buffer is also tested. A matching line must still be accepted while a new line stalls, and the later dispatch order must show the merged row leading on popcount.

// File: rtl/lbc_pkg.sv
package lbc_pkg;
  localparam int ROWS       = 4;
  localparam int ROW_W      = $clog2(ROWS);
  localparam int LINE_BYTES = 16;
  localparam int CNT_W      = $clog2(LINE_BYTES + 1);

  typedef struct packed {
    logic             wrEn;
    logic             wrMerge;
    logic [ROW_W-1:0] wrIdx;
    logic             clrEn;
    logic [ROW_W-1:0] clrIdx;
  } lbc_strobe_t;

  function automatic logic [CNT_W-1:0] popCount(input logic [LINE_BYTES-1:0] bits);
    logic [CNT_W-1:0] acc;
    acc = '0;
    for (int b = 0; b < LINE_BYTES; b++) acc = acc + CNT_W'(bits[b]);
    return acc;
  endfunction
endpackage

// File: rtl/lbc_rows.sv
module lbc_rows
  import lbc_pkg::*;
#(
  parameter int ADDR_W = 28
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  lbc_strobe_t           strobe,
  input  logic [ADDR_W-1:0]     reqLine,
  input  logic [LINE_BYTES-1:0] reqMask,
  output logic [ROWS-1:0]       matchVec,
  output logic [ROWS-1:0]       freeVec,
  output logic [ROW_W-1:0]      selIdx,
  output logic                  selValid,
  output logic [ADDR_W-1:0]     dispLine,
  output logic [LINE_BYTES-1:0] dispMask,
  output logic                  dispFull
);
  logic [ROWS-1:0]       rowValid;
  logic [ADDR_W-1:0]     rowLine [ROWS];
  logic [LINE_BYTES-1:0] rowMask [ROWS];
  logic [CNT_W-1:0]      rowCnt  [ROWS];

  for (genvar g = 0; g < ROWS; g++) begin : gRow
    assign rowCnt[g]   = popCount(rowMask[g]);
    assign matchVec[g] = rowValid[g] && (rowLine[g] == reqLine);
    assign freeVec[g]  = !rowValid[g];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rowValid[g] <= 1'b0;
        rowLine[g]  <= '0;
        rowMask[g]  <= '0;
      end else if (strobe.wrEn && strobe.wrIdx == ROW_W'(g)) begin
        rowValid[g] <= 1'b1;
        if (strobe.wrMerge) begin
          rowMask[g] <= rowMask[g] | reqMask;
        end else begin
          rowLine[g] <= reqLine;
          rowMask[g] <= reqMask;
        end
      end else if (strobe.clrEn && strobe.clrIdx == ROW_W'(g)) begin
        rowValid[g] <= 1'b0;
      end
    end
  end

  // strict greater-than keeps the lowest index on a tie
  always_comb begin
    logic [CNT_W-1:0] bestCnt;
    bestCnt  = '0;
    selIdx   = '0;
    selValid = 1'b0;
    for (int i = 0; i < ROWS; i++) begin
      if (rowValid[i] && (!selValid || rowCnt[i] > bestCnt)) begin
        selValid = 1'b1;
        selIdx   = ROW_W'(i);
        bestCnt  = rowCnt[i];
      end
    end
  end

  assign dispLine = rowLine[selIdx];
  assign dispMask = rowMask[selIdx];
  assign dispFull = selValid && (rowMask[selIdx] == {LINE_BYTES{1'b1}});

  logic dupLine;
  always_comb begin
    dupLine = 1'b0;
    for (int i = 0; i < ROWS; i++)
      for (int j = i + 1; j < ROWS; j++)
        if (rowValid[i] && rowValid[j] && rowLine[i] == rowLine[j]) dupLine = 1'b1;
  end

  p_unique_line_r2: assert property (@(posedge clk) disable iff (!rst_n) !dupLine);

  p_merge_keeps_bytes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.wrEn && strobe.wrMerge) |=>
      ((rowMask[$past(strobe.wrIdx)] & $past(reqMask)) == $past(reqMask)));

  p_freed_row_r8: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.clrEn |=> !rowValid[$past(strobe.clrIdx)]);
endmodule

// File: rtl/lbc_ctrl.sv
module lbc_ctrl
  import lbc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic             dispReady,
  output logic             dispValid,
  input  logic [ROWS-1:0]  matchVec,
  input  logic [ROWS-1:0]  freeVec,
  input  logic [ROW_W-1:0] selIdx,
  input  logic             selValid,
  output lbc_strobe_t      strobe
);
  logic            departing;
  logic [ROWS-1:0] matchLive;
  logic            hasMatch, hasFree;
  logic [ROW_W-1:0] matchIdx, freeIdx;

  assign departing = selValid && dispReady;

  always_comb begin
    matchLive = matchVec;
    if (departing) matchLive[selIdx] = 1'b0;
  end

  always_comb begin
    hasMatch = 1'b0;
    matchIdx = '0;
    hasFree  = 1'b0;
    freeIdx  = '0;
    for (int i = 0; i < ROWS; i++) begin
      if (matchLive[i] && !hasMatch) begin
        hasMatch = 1'b1;
        matchIdx = ROW_W'(i);
      end
      if (freeVec[i] && !hasFree) begin
        hasFree = 1'b1;
        freeIdx = ROW_W'(i);
      end
    end
  end

  assign reqReady  = hasMatch || hasFree;
  assign dispValid = selValid;

  always_comb begin
    strobe.wrEn    = reqValid && reqReady;
    strobe.wrMerge = hasMatch;
    strobe.wrIdx   = hasMatch ? matchIdx : freeIdx;
    strobe.clrEn   = departing;
    strobe.clrIdx  = selIdx;
  end

  p_hold_offer_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dispValid && !dispReady) |=> dispValid);

  p_stall_only_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && !reqReady) |-> (freeVec == '0));

  p_no_merge_departing_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.wrEn && strobe.clrEn) |-> (strobe.wrIdx != strobe.clrIdx));
endmodule

// File: rtl/load_coalescer.sv
module load_coalescer
  import lbc_pkg::*;
#(
  parameter int ADDR_W = 28
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reqValid,
  output logic                  reqReady,
  input  logic [ADDR_W-1:0]     reqLine,
  input  logic [LINE_BYTES-1:0] reqMask,
  output logic                  dispValid,
  input  logic                  dispReady,
  output logic [ADDR_W-1:0]     dispLine,
  output logic [LINE_BYTES-1:0] dispMask,
  output logic                  dispFull
);
  lbc_strobe_t      strobe;
  logic [ROWS-1:0]  matchVec, freeVec;
  logic [ROW_W-1:0] selIdx;
  logic             selValid;

  lbc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .reqValid(reqValid), .reqReady(reqReady),
    .dispReady(dispReady), .dispValid(dispValid),
    .matchVec(matchVec), .freeVec(freeVec),
    .selIdx(selIdx), .selValid(selValid),
    .strobe(strobe)
  );

  lbc_rows #(.ADDR_W(ADDR_W)) u_rows (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .reqLine(reqLine), .reqMask(reqMask),
    .matchVec(matchVec), .freeVec(freeVec),
    .selIdx(selIdx), .selValid(selValid),
    .dispLine(dispLine), .dispMask(dispMask), .dispFull(dispFull)
  );
endmodule

// File: tb/sim_load_coalescer.sv
module sim_load_coalescer;
  localparam int AW = 28;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqReady;
  logic [AW-1:0] reqLine = '0;
  logic [15:0]   reqMask = '0;
  logic          dispValid;
  logic          dispReady = 1'b0;
  logic [AW-1:0] dispLine;
  logic [15:0]   dispMask;
  logic          dispFull;

  always #4 clk = ~clk;

  load_coalescer #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .reqValid(reqValid), .reqReady(reqReady), .reqLine(reqLine), .reqMask(reqMask),
    .dispValid(dispValid), .dispReady(dispReady),
    .dispLine(dispLine), .dispMask(dispMask), .dispFull(dispFull)
  );

  typedef struct {
    logic [AW-1:0] line;
    logic [15:0]   mask;
    logic          full;
    string         tag;
  } exp_t;

  exp_t expQ[$];
  int   nChecks = 0;
  int   nFails  = 0;
  bit   finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expect_disp(input logic [AW-1:0] l, input logic [15:0] m, input string tag);
    exp_t e;
    e.line = l; e.mask = m; e.full = (m == 16'hFFFF); e.tag = tag;
    expQ.push_back(e);
  endtask

  // drive after the rising edge; holds until accepted
  task automatic send(input logic [AW-1:0] l, input logic [15:0] m);
    reqValid = 1'b1; reqLine = l; reqMask = m;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    @(posedge clk); #1;
    reqValid = 1'b0;
  endtask

  task automatic drain();
    dispReady = 1'b1;
    for (int t = 0; t < 50 && (expQ.size() != 0 || dispValid); t++) @(posedge clk);
    #1;
    dispReady = 1'b0;
    chk(expQ.size() == 0, "R8 all expected rows dispatched", expQ.size(), 0);
    @(negedge clk);
    chk(!dispValid, "R8 buffer empty after drain", dispValid, 0);
    @(posedge clk); #1;
  endtask

  // scoreboard monitor: handshake seen mid-cycle completes on the next edge
  always @(negedge clk) begin
    if (rst_n && dispValid && dispReady) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R8 unexpected dispatch", dispLine, 0);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        chk(dispLine == e.line, {e.tag, " line"}, dispLine, e.line);
        chk(dispMask == e.mask, {e.tag, " mask"}, dispMask, e.mask);
        chk(dispFull == e.full, "R6 full flag", dispFull, e.full);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "watchdog expired", 0, 1);
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!dispValid, "R1 no offer after reset", dispValid, 0);
    chk(reqReady, "R1 ready after reset", reqReady, 1);
    @(posedge clk); #1;

    // merge, priority and tie ordering
    send(28'h10, 16'h0001);
    send(28'h10, 16'h0002);
    send(28'h20, 16'h00F0);
    send(28'h30, 16'h0003);
    @(negedge clk);
    chk(dispValid, "R4 offer present", dispValid, 1);
    chk(dispLine == 28'h20, "R4 largest popcount offered", dispLine, 28'h20);
    repeat (3) @(negedge clk);
    chk(dispValid && dispLine == 28'h20, "R8 offer held without ready", dispLine, 28'h20);
    @(posedge clk); #1;
    expect_disp(28'h20, 16'h00F0, "R4 first by popcount");
    expect_disp(28'h10, 16'h0003, "R2 R5 merged row wins tie");
    expect_disp(28'h30, 16'h0003, "R3 separate row");
    drain();

    // full line
    send(28'h40, 16'h00FF);
    send(28'h40, 16'hFF00);
    send(28'h50, 16'h7FFF);
    @(negedge clk);
    chk(dispFull, "R6 full flag on all-ones row", dispFull, 1);
    @(posedge clk); #1;
    expect_disp(28'h40, 16'hFFFF, "R6 full row first");
    expect_disp(28'h50, 16'h7FFF, "R6 fifteen bytes");
    drain();

    // backpressure when all rows occupied
    send(28'h1, 16'h0001);
    send(28'h2, 16'h0001);
    send(28'h3, 16'h0001);
    send(28'h4, 16'h0001);
    reqValid = 1'b1; reqLine = 28'h5; reqMask = 16'h0001;
    @(negedge clk);
    chk(!reqReady, "R7 new line stalls when full", reqReady, 0);
    @(posedge clk); #1;
    reqLine = 28'h2; reqMask = 16'h0F00;
    @(negedge clk);
    chk(reqReady, "R7 matching line accepted when full", reqReady, 1);
    @(posedge clk); #1;
    reqValid = 1'b0;
    expect_disp(28'h2, 16'h0F01, "R7 merged row leads");
    expect_disp(28'h1, 16'h0001, "R5 tie lowest index");
    expect_disp(28'h3, 16'h0001, "R5 tie next index");
    expect_disp(28'h4, 16'h0001, "R5 tie last index");
    drain();

    // arrival to departing line
    send(28'h60, 16'h000F);
    expect_disp(28'h60, 16'h000F, "R9 departing row keeps old mask");
    expect_disp(28'h60, 16'h00F0, "R9 new row for same line");
    dispReady = 1'b1;
    reqValid = 1'b1; reqLine = 28'h60; reqMask = 16'h00F0;
    @(negedge clk);
    chk(reqReady, "R9 load accepted while row departs", reqReady, 1);
    @(posedge clk); #1;
    reqValid = 1'b0;
    dispReady = 1'b0;
    drain();

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule